// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block converts a logical address from a processor into a physical address under a single-level paging scheme. The logical address splits into a page number (upper bits) and a byte offset (lower `OFF_W` bits). The page number selects a page-table entry, and the entry supplies a frame number. The frame number is placed above the unchanged offset to form the physical address.

Eight recently used translations are held in a small fully associative cache. Each cached entry is tagged with the address-space identifier of the process that loaded it. A request that finds its page number in the cache under the current identifier is answered from the cache, with no memory traffic.

On a miss, the block issues one read at `ptbr + page` on a simple memory read port. It checks the returned entry, stores a valid entry in the cache slot selected in rotation, and answers. Page numbers outside the table length, invalid entries and access rights that forbid the request produce a fault code in place of an address.

Top module: `pg_xlate`

## Requirements
- R1: A successful response carries `rsp_paddr = {frame, offset}`, where offset is the low `OFF_W` bits of `req_vaddr` and frame is the low `PA_W-OFF_W` bits of the page-table entry.
- R2: A request whose page number and identifier are in the cache gets `rsp_valid` on the first clock edge after it is accepted, and no memory read is made.
- R3: On a miss, exactly one memory read is issued, at address `ptbr + page`. Its entry is cached, so the same request made again is a hit.
- R4: A cached entry hits only when its stored identifier equals `req_asid`. The same page under another identifier misses and is read from that identifier's table.
- R5: Bit 7 of a page-table entry is its valid bit. A clear valid bit gives fault code 2. That entry is not cached, so a retry reads memory again.
- R6: Bits 6, 5 and 4 of an entry permit read, write and fetch. `req_kind` 0 is read, 1 is write and 2 is fetch; kind 3 is never permitted. An access whose right is clear gives fault code 3, whether the translation comes from the cache or from memory.
- R7: A page number greater than or equal to `ptlr` gives fault code 1, and no memory read is made.
- R8: Refills go into the 8 slots in rotation, starting at slot 0 after reset. The ninth refill therefore evicts the first translation loaded.
- R9: A `flush` pulse invalidates every cache entry in one cycle.
- R10: After reset, `rsp_valid` and `mem_rd` are low, `req_ready` is high and the cache is empty.
- R11: `rsp_valid` is a one-cycle pulse per request. On a fault, `rsp_paddr` is zero; fault code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_vaddr | input | LA_W | Logical address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_asid | input | ASID_W | Current address-space identifier |
| ptbr | input | MA_W | Page-table base address |
| ptlr | input | LA_W-OFF_W+1 | Number of entries in the page table |
| mem_rd | output | 1 | One-cycle page-table read strobe |
| mem_addr | output | MA_W | Page-table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | PTE_W | Page-table entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |

## Verification
The assertions assume three things about the inputs. The memory answers each read exactly once, and only after the strobe. `req_valid` is raised only while `req_ready` is high. `flush` arrives only while the block is idle. The bench models a memory that returns data one cycle after each strobe. It raises each request for a single cycle, waits for that request's response, and only then raises another request or a flush.

// File: rtl/pg_xlate.sv
module pg_xlate #(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 15,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8,
  parameter int MA_W    = 16,
  parameter int PTE_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LA_W-1:0]         req_vaddr,
  input  logic [1:0]              req_kind,
  input  logic [ASID_W-1:0]       req_asid,
  input  logic [MA_W-1:0]         ptbr,
  input  logic [LA_W-OFF_W:0]     ptlr,
  output logic                    mem_rd,
  output logic [MA_W-1:0]         mem_addr,
  input  logic                    mem_rvalid,
  input  logic [PTE_W-1:0]        mem_rdata,
  output logic                    rsp_valid,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic [1:0]              rsp_fault
);
  localparam int PN_W = LA_W - OFF_W;
  localparam int FR_W = PA_W - OFF_W;
  localparam int IX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [ENTRIES-1:0] tv;
  logic [PN_W-1:0]    tpn   [ENTRIES];
  logic [ASID_W-1:0]  tasid [ENTRIES];
  logic [FR_W-1:0]    tfr   [ENTRIES];
  logic [2:0]         tperm [ENTRIES];
  logic [IX_W-1:0]    rr;

  logic [PN_W-1:0]    pn_q;
  logic [OFF_W-1:0]   off_q;
  logic [1:0]         kind_q;
  logic [ASID_W-1:0]  asid_q;
  logic [MA_W-1:0]    base_q;

  wire [PN_W-1:0]  pn_in  = req_vaddr[LA_W-1:OFF_W];
  wire [OFF_W-1:0] off_in = req_vaddr[OFF_W-1:0];
  wire             accept = req_valid && st == S_IDLE;
  wire             too_far = {1'b0, pn_in} >= ptlr;

  logic [ENTRIES-1:0] hit_vec;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = tv[i] && tpn[i] == pn_in && tasid[i] == req_asid;
  end

  logic [FR_W-1:0] hit_fr;
  logic [2:0]      hit_perm;
  always_comb begin
    hit_fr   = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) begin
        hit_fr   = hit_fr | tfr[i];
        hit_perm = hit_perm | tperm[i];
      end
  end

  function automatic logic allowed(input logic [2:0] perm, input logic [1:0] kind);
    case (kind)
      2'd0:    allowed = perm[2];
      2'd1:    allowed = perm[1];
      2'd2:    allowed = perm[0];
      default: allowed = 1'b0;
    endcase
  endfunction

  wire [2:0]      pte_perm = mem_rdata[PTE_W-2:PTE_W-4];
  wire [FR_W-1:0] pte_fr   = mem_rdata[FR_W-1:0];
  wire            pte_ok   = mem_rdata[PTE_W-1];

  assign req_ready = st == S_IDLE;
  assign mem_rd    = st == S_ISSUE;
  assign mem_addr  = base_q + MA_W'(pn_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tv        <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= '0;
      pn_q      <= '0;
      off_q     <= '0;
      kind_q    <= '0;
      asid_q    <= '0;
      base_q    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          pn_q   <= pn_in;
          off_q  <= off_in;
          kind_q <= req_kind;
          asid_q <= req_asid;
          base_q <= ptbr;
          if (too_far) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 2'd1;
            rsp_paddr <= '0;
          end else if (|hit_vec) begin
            rsp_valid <= 1'b1;
            if (allowed(hit_perm, req_kind)) begin
              rsp_fault <= 2'd0;
              rsp_paddr <= {hit_fr, off_in};
            end else begin
              rsp_fault <= 2'd3;
              rsp_paddr <= '0;
            end
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          if (!pte_ok) begin
            rsp_fault <= 2'd2;
            rsp_paddr <= '0;
          end else begin
            tv[rr]    <= 1'b1;
            tpn[rr]   <= pn_q;
            tasid[rr] <= asid_q;
            tfr[rr]   <= pte_fr;
            tperm[rr] <= pte_perm;
            rr        <= (rr == IX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
            if (allowed(pte_perm, kind_q)) begin
              rsp_fault <= 2'd0;
              rsp_paddr <= {pte_fr, off_q};
            end else begin
              rsp_fault <= 2'd3;
              rsp_paddr <= '0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (flush) tv <= '0;
    end
  end

  p_one_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_len_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && too_far) |=> (rsp_valid && rsp_fault == 2'd1 && !mem_rd && st == S_IDLE));

  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !too_far && |hit_vec) |=> (rsp_valid && !mem_rd));

  p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_q);

  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tv == '0);
endmodule

// File: tb/pg_xlate_bench.sv
module pg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [3:0]  req_asid = '0;
  logic [15:0] ptbr = '0;
  logic [4:0]  ptlr = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  always #5 clk = ~clk;

  pg_xlate u_pg_xlate (.*);

  function automatic logic [7:0] pte_of(input logic [15:0] a);
    logic [2:0] perm;
    case (a[1:0])
      2'd0: perm = 3'b100;
      2'd1: perm = 3'b110;
      2'd2: perm = 3'b001;
      default: perm = 3'b111;
    endcase
    return {a[3:0] != 4'd5, perm, 1'b0, a[2:0] ^ {a[9], 2'b01}};
  endfunction

  int nreads = 0;
  logic [15:0] last_addr = '0;
  always @(posedge clk) begin
    mem_rvalid <= mem_rd && rst_n;
    mem_rdata  <= pte_of(mem_addr);
    if (mem_rd) begin
      nreads    <= nreads + 1;
      last_addr <= mem_addr;
    end
  end

  int checks = 0, fails = 0;
  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  logic [1:0]  got_fault;
  logic [14:0] got_paddr;
  int          got_reads, got_wait;

  task automatic xact(input logic [1:0] k, input logic [3:0] a, input logic [15:0] b,
                      input logic [4:0] l, input logic [15:0] va);
    int r0;
    @(negedge clk);
    r0 = nreads;
    req_kind = k; req_asid = a; ptbr = b; ptlr = l; req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_wait = 0;
    while (!rsp_valid && got_wait < 40) begin
      @(negedge clk);
      got_wait++;
    end
    got_fault = rsp_fault;
    got_paddr = rsp_paddr;
    got_reads = nreads - r0;
    @(negedge clk);
    check(!rsp_valid, "R11 pulse", rsp_valid, 0);
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  asid;
    logic [15:0] base;
    logic [15:0] va;
    logic [1:0]  fault;
    logic [14:0] pa;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd1, 16'h0100, 16'h0004, 2'd0, 15'h1004, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h0ABC, 2'd0, 15'h1ABC, 2'd0},
    '{2'd1, 4'd1, 16'h0100, 16'h0004, 2'd3, 15'h0000, 2'd0},
    '{2'd1, 4'd1, 16'h0100, 16'h1010, 2'd0, 15'h0010, 2'd1},
    '{2'd2, 4'd1, 16'h0100, 16'h2020, 2'd0, 15'h3020, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h2020, 2'd3, 15'h0000, 2'd0},
    '{2'd0, 4'd1, 16'h0100, 16'h5000, 2'd2, 15'h0000, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h5000, 2'd2, 15'h0000, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'hC000, 2'd1, 15'h0000, 2'd0},
    '{2'd0, 4'd1, 16'h0100, 16'hF000, 2'd1, 15'h0000, 2'd0},
    '{2'd2, 4'd1, 16'h0100, 16'h3FFF, 2'd0, 15'h2FFF, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'hB000, 2'd0, 15'h2000, 2'd1},
    '{2'd0, 4'd2, 16'h0200, 16'h0004, 2'd0, 15'h5004, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h0004, 2'd0, 15'h1004, 2'd0},
    '{2'd1, 4'd1, 16'h0100, 16'h9123, 2'd0, 15'h0123, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h4456, 2'd0, 15'h5456, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h6001, 2'd3, 15'h0000, 2'd1},
    '{2'd0, 4'd1, 16'h0100, 16'h0004, 2'd0, 15'h1004, 2'd1},
    '{2'd1, 4'd1, 16'h0100, 16'h1010, 2'd0, 15'h0010, 2'd1},
    '{2'd2, 4'd1, 16'h0100, 16'h3007, 2'd0, 15'h2007, 2'd0}
  };

  initial begin
    repeat (30000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid && !mem_rd, "R10 idle outputs", {rsp_valid, mem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R10 ready", req_ready, 1);

    // R1 R2 R3 R4 R5 R6 R7 R8 exercised by the vector walk (tag R8 on slot eviction rows 17-18)
    for (int i = 0; i < NV; i++) begin
      xact(VECS[i].kind, VECS[i].asid, VECS[i].base, 5'd12, VECS[i].va);
      check(got_fault == VECS[i].fault, $sformatf("R6 fault vec %0d", i), got_fault, VECS[i].fault);
      check(got_paddr == VECS[i].pa, $sformatf("R1 paddr vec %0d", i), got_paddr, VECS[i].pa);
      check(got_reads == VECS[i].reads, $sformatf("R8 reads vec %0d", i), got_reads, VECS[i].reads);
      if (VECS[i].reads == 0 && VECS[i].fault != 2'd1)
        check(got_wait == 0, $sformatf("R2 latency vec %0d", i), got_wait, 0);
      if (VECS[i].reads == 1) begin
        check(last_addr == VECS[i].base + 16'(VECS[i].va[15:12]),
              $sformatf("R3 addr vec %0d", i), last_addr, VECS[i].base + 16'(VECS[i].va[15:12]));
        check(got_wait == 2, $sformatf("R3 latency vec %0d", i), got_wait, 2);
      end
    end

    // R9: flush empties the cache; page 3 was a hit just above
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    xact(2'd2, 4'd1, 16'h0100, 5'd12, 16'h3007);
    check(got_reads == 1, "R9 refetch after flush", got_reads, 1);
    check(got_paddr == 15'h2007, "R9 paddr", got_paddr, 15'h2007);

    // R7: zero length table rejects everything
    xact(2'd0, 4'd1, 16'h0100, 5'd0, 16'h3007);
    check(got_fault == 2'd1 && got_reads == 0, "R7 zero length", {got_fault, 8'(got_reads)}, 16'h100);

    // R7: full length table allows the top page
    xact(2'd0, 4'd1, 16'h0100, 5'd16, 16'hF0AB);
    check(got_fault == 2'd0, "R7 top page fault", got_fault, 0);
    check(got_paddr == 15'h60AB, "R1 top page paddr", got_paddr, 15'h60AB);
    check(last_addr == 16'h010F, "R3 top page addr", last_addr, 16'h010F);

    // R6: kind 3 is never permitted, even on a hit
    xact(2'd3, 4'd1, 16'h0100, 5'd16, 16'hF000);
    check(got_fault == 2'd3 && got_reads == 0, "R6 kind 3", got_fault, 3);

    // R4: page 15 under another identifier misses
    xact(2'd0, 4'd2, 16'h0200, 5'd16, 16'hF000);
    check(got_reads == 1 && got_paddr == 15'h2000, "R4 other asid", got_paddr, 15'h2000);

    // R10: reset empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    xact(2'd0, 4'd2, 16'h0200, 5'd16, 16'hF000);
    check(got_reads == 1, "R10 cache empty after reset", got_reads, 1);

    finish_up();
  end
endmodule